// File: doc/BRIEF.md
# Sampling Delay Window Selector

This block picks a receive sampling delay from the result of a calibration sweep. It takes a 64-bit pass/fail map, where bit i is set when delay step i sampled data correctly. It walks the map one bit per clock from step 0 upward and tracks the longest unbroken stretch of passing steps. From that stretch it computes a delay index inside the window. The delay sits near the left edge when the window begins at step 0, and at the middle of the window otherwise.

The 64 delay cells are built as two 32-cell lines in series. The block therefore also converts the chosen index into settings for those two lines:
- a 5-bit tap for the first line,
- a 5-bit tap for the second line,
- an enable for the second line.

A narrow mode handles 32-step calibration. In this mode the upper half of the map is ignored and the second line is never enabled.

A sweep controller starts a scan by pulsing `start_i` with the map and mode applied. A one-cycle `done_o` pulse follows. The results stay on the outputs until the next accepted start.

Top module: `delay_window_sel`

## Requirements
- R1: The block finds the longest run of consecutive set bits in the map, scanning from bit 0 upward. It reports that run's length on `len_o`, which can take any value from 0 to 64.
- R2: When two runs have the same length, the one that starts at the lower bit is kept.
- R3: If the kept run starts at bit 0, `delay_o` is floor(len/3). Otherwise `delay_o` is start + floor(len/2), taken modulo 64.
- R4: A map with no set bits after masking sets `err_o` to 1 and sets both `delay_o` and `len_o` to 0. Any map with at least one set bit leaves `err_o` at 0.
- R5: The scan stops early in one case only: bits 63..32 of the map are all zero, a run of at least 12 has just ended, and the kept run starts below bit 4. A later, longer run is then not considered. If any of bits 63..32 is set, the scan always covers all 64 bits.
- R6: With `wide_i` = 0 (32-step mode), bits 63..32 of the map are treated as zero.
- R7: For `delay_o` < 32, the outputs are `stage1_o` = `delay_o`, `stage2_o` = 0 and `stage2_en_o` = 0. For `delay_o` >= 32, the outputs are `stage1_o` = 31, `stage2_o` = `delay_o` - 32 and `stage2_en_o` = 1.
- R8: `stage2_en_o` is always 0 when the accepted scan had `wide_i` = 0.
- R9: `done_o` is high for exactly one cycle, at most 67 cycles after the cycle in which start was applied. All result outputs hold their values until the next accepted start.
- R10: `start_i` is accepted only while `busy_o` is 0. A start applied while a scan is running has no effect on that scan's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request; map_i and wide_i are sampled with it |
| map_i | input | 64 | Pass/fail map, bit i = delay step i |
| wide_i | input | 1 | 1 = 64-step mode, 0 = 32-step mode |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle result pulse |
| err_o | output | 1 | No passing step found |
| delay_o | output | 6 | Chosen delay index |
| len_o | output | 7 | Length of the kept run |
| stage1_o | output | 5 | First delay line tap |
| stage2_o | output | 5 | Second delay line tap |
| stage2_en_o | output | 1 | Second delay line enable |

## Verification
The bench covers the following corner cases:
- **Equal-length runs.** A design that replaces the kept run on equal length would return the later window.
- **Early exit, two maps.** The bench uses a 12-long window at step 0 followed by a longer one, once with the upper half clear and once with a single upper bit set. A design with the wrong exit condition would either pick the longer window in the first map or stop in the second.
- **Map edges.** A run that ends exactly at bit 63, a run starting at bit 32, and the all-ones map check the end-of-map run closure, the one-third versus one-half rule, and the split into two lines at the 32 boundary.
- **32-step masking.** Maps whose only set bits lie in the upper half are run in 32-step mode. If the mask were missing, these would produce a valid window instead of the error flag.
- **Start during a scan.** A start issued mid-scan must leave the earlier result in place; a design that restarted on it would report the second map instead.

// File: rtl/dws_pkg.sv
package dws_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_FIN  = 2'd2
  } scan_state_e;
endpackage

// File: rtl/dws_run_scanner.sv
module dws_run_scanner
  import dws_pkg::*;
#(
  parameter int MAP_W       = 64,
  parameter int EARLY_LEN   = 12,
  parameter int EARLY_START = 4,
  localparam int IDX_W = $clog2(MAP_W),
  localparam int LEN_W = $clog2(MAP_W) + 1,
  localparam int HALF  = MAP_W / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [MAP_W-1:0] map_i,
  input  logic             wide_i,
  output logic             busy_o,
  output logic             fin_o,
  output logic             wide_o,
  output logic [IDX_W-1:0] best_start_o,
  output logic [LEN_W-1:0] best_len_o
);
  scan_state_e      state_q;
  logic [MAP_W-1:0] map_q;
  logic             wide_q, upper_zero_q;
  logic [IDX_W-1:0] idx_q, cur_start_q, best_start_q;
  logic [LEN_W-1:0] cur_len_q, best_len_q;

  logic             bit_v, at_end, run_ends, take, early, last;
  logic [IDX_W-1:0] end_start, nb_start;
  logic [LEN_W-1:0] end_len, nb_len;
  logic [MAP_W-1:0] masked_map;

  always_comb begin
    masked_map = map_i;
    if (!wide_i) masked_map[MAP_W-1:HALF] = '0;
  end

  always_comb begin
    bit_v     = map_q[idx_q];
    at_end    = (idx_q == IDX_W'(MAP_W - 1));
    // a run closes on a clear bit after set bits, or on a set bit at the top
    run_ends  = (!bit_v && cur_len_q != '0) || (bit_v && at_end);
    end_len   = bit_v ? cur_len_q + LEN_W'(1) : cur_len_q;
    end_start = (bit_v && cur_len_q == '0) ? idx_q : cur_start_q;
    take      = run_ends && (end_len > best_len_q);
    nb_start  = take ? end_start : best_start_q;
    nb_len    = take ? end_len : best_len_q;
    early     = run_ends && upper_zero_q && (end_len >= LEN_W'(EARLY_LEN))
                && (nb_start < IDX_W'(EARLY_START));
    last      = at_end || early;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      map_q        <= '0;
      wide_q       <= 1'b0;
      upper_zero_q <= 1'b1;
      idx_q        <= '0;
      cur_start_q  <= '0;
      cur_len_q    <= '0;
      best_start_q <= '0;
      best_len_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q      <= ST_SCAN;
          map_q        <= masked_map;
          wide_q       <= wide_i;
          upper_zero_q <= (masked_map[MAP_W-1:HALF] == '0);
          idx_q        <= '0;
          cur_start_q  <= '0;
          cur_len_q    <= '0;
          best_start_q <= '0;
          best_len_q   <= '0;
        end
        ST_SCAN: begin
          best_start_q <= nb_start;
          best_len_q   <= nb_len;
          if (bit_v && !at_end) begin
            if (cur_len_q == '0) cur_start_q <= idx_q;
            cur_len_q <= cur_len_q + LEN_W'(1);
          end else begin
            cur_len_q <= '0;
          end
          if (last) state_q <= ST_FIN;
          else      idx_q   <= idx_q + IDX_W'(1);
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign fin_o        = (state_q == ST_FIN);
  assign wide_o       = wide_q;
  assign best_start_o = best_start_q;
  assign best_len_o   = best_len_q;

  // R10: a start during a scan leaves the captured map alone
  a_r10_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(map_q));
  // R1: the kept length never shrinks within a scan
  a_r1_best_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SCAN) |=> (best_len_q >= $past(best_len_q)));
  // R6: 32-step mode never holds upper bits
  a_r6_upper_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !wide_q) |-> (map_q[MAP_W-1:HALF] == '0));
endmodule

// File: rtl/dws_phase_pick.sv
module dws_phase_pick #(
  parameter int MAP_W = 64,
  localparam int IDX_W = $clog2(MAP_W),
  localparam int LEN_W = $clog2(MAP_W) + 1
) (
  input  logic [IDX_W-1:0] start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [IDX_W-1:0] delay_o,
  output logic             err_o
);
  logic [LEN_W:0] sum;
  logic [LEN_W-1:0] third;

  always_comb begin
    third = len_i / LEN_W'(3);
    sum   = (LEN_W+1)'(start_i) + (LEN_W+1)'(len_i >> 1);
    err_o = (len_i == '0);
    if (err_o)               delay_o = '0;
    else if (start_i == '0)  delay_o = third[IDX_W-1:0];
    else                     delay_o = sum[IDX_W-1:0]; // modulo MAP_W
  end
endmodule

// File: rtl/dws_stage_split.sv
module dws_stage_split #(
  parameter int MAP_W = 64,
  parameter int CELLS = 32,
  localparam int IDX_W = $clog2(MAP_W),
  localparam int STG_W = $clog2(CELLS)
) (
  input  logic [IDX_W-1:0] delay_i,
  input  logic             wide_i,
  output logic [STG_W-1:0] stage1_o,
  output logic [STG_W-1:0] stage2_o,
  output logic             stage2_en_o
);
  logic [IDX_W-1:0] rem;

  always_comb begin
    rem = delay_i - IDX_W'(CELLS);
    if (delay_i < IDX_W'(CELLS)) begin
      stage1_o    = delay_i[STG_W-1:0];
      stage2_o    = '0;
      stage2_en_o = 1'b0;
    end else begin
      stage1_o    = '1;
      stage2_o    = rem[STG_W-1:0];
      stage2_en_o = wide_i;
    end
  end
endmodule

// File: rtl/delay_window_sel.sv
module delay_window_sel #(
  parameter int MAP_W       = 64,
  parameter int CELLS       = 32,
  parameter int EARLY_LEN   = 12,
  parameter int EARLY_START = 4,
  localparam int IDX_W = $clog2(MAP_W),
  localparam int LEN_W = $clog2(MAP_W) + 1,
  localparam int STG_W = $clog2(CELLS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [MAP_W-1:0] map_i,
  input  logic             wide_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [IDX_W-1:0] delay_o,
  output logic [LEN_W-1:0] len_o,
  output logic [STG_W-1:0] stage1_o,
  output logic [STG_W-1:0] stage2_o,
  output logic             stage2_en_o
);
  logic             fin, wide_s, err_c, en_c;
  logic [IDX_W-1:0] best_start, delay_c;
  logic [LEN_W-1:0] best_len;
  logic [STG_W-1:0] s1_c, s2_c;

  dws_run_scanner #(
    .MAP_W(MAP_W), .EARLY_LEN(EARLY_LEN), .EARLY_START(EARLY_START)
  ) u_scan (
    .clk_i, .rst_ni, .start_i, .map_i, .wide_i,
    .busy_o, .fin_o(fin), .wide_o(wide_s),
    .best_start_o(best_start), .best_len_o(best_len)
  );

  dws_phase_pick #(.MAP_W(MAP_W)) u_pick (
    .start_i(best_start), .len_i(best_len), .delay_o(delay_c), .err_o(err_c)
  );

  dws_stage_split #(.MAP_W(MAP_W), .CELLS(CELLS)) u_split (
    .delay_i(delay_c), .wide_i(wide_s),
    .stage1_o(s1_c), .stage2_o(s2_c), .stage2_en_o(en_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      delay_o     <= '0;
      len_o       <= '0;
      stage1_o    <= '0;
      stage2_o    <= '0;
      stage2_en_o <= 1'b0;
    end else begin
      done_o <= fin;
      if (fin) begin
        err_o       <= err_c;
        delay_o     <= delay_c;
        len_o       <= best_len;
        stage1_o    <= s1_c;
        stage2_o    <= s2_c;
        stage2_en_o <= en_c;
      end
    end
  end

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !$past(fin)) |-> $stable(delay_o) && $stable(len_o));
  a_r4_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (delay_o == '0 && len_o == '0));
  a_r7_split_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage2_en_o |-> (stage1_o == '1 && delay_o >= IDX_W'(CELLS)));
  a_r8_narrow_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && !wide_s) |=> !stage2_en_o);
  a_r1_len_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_o <= LEN_W'(MAP_W));
endmodule

// File: tb/delay_window_sel_bench.sv
`timescale 1ns/1ps
module delay_window_sel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] map = '0;
  logic        wide = 1'b1;
  logic        busy, done, err, en;
  logic [5:0]  delay;
  logic [6:0]  len;
  logic [4:0]  s1, s2;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  delay_window_sel u_delay_window_sel (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .map_i(map), .wide_i(wide),
    .busy_o(busy), .done_o(done), .err_o(err), .delay_o(delay), .len_o(len),
    .stage1_o(s1), .stage2_o(s2), .stage2_en_o(en)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R9: pulse start, wait for done, confirm one-cycle pulse
  task automatic run_scan(input logic [63:0] m, input logic w);
    int cyc = 0;
    @(negedge clk);
    map = m; wide = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 80) begin
      @(negedge clk);
      cyc++;
    end
    check("R9 done latency", 64'(cyc <= 66), 64'd1);
    @(negedge clk);
    check("R9 done one cycle", 64'(done), 64'd0);
  endtask

  task automatic expect_res(input string tag, input int d, input int l, input bit e,
                            input int a, input int b, input bit g);
    check({tag, " delay"}, 64'(delay), 64'(d));
    check({tag, " len"}, 64'(len), 64'(l));
    check({tag, " err"}, 64'(err), 64'(e));
    check({tag, " stage1"}, 64'(s1), 64'(a));
    check({tag, " stage2"}, 64'(s2), 64'(b));
    check({tag, " stage2_en"}, 64'(en), 64'(g));
  endtask

  task automatic t_reset();
    check("R9 reset done", 64'(done), 64'd0);
    check("R10 reset busy", 64'(busy), 64'd0);
    expect_res("R4 reset", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_start_zero();
    run_scan(64'h1FF, 1'b1);
    expect_res("R3 start0", 3, 9, 0, 3, 0, 0);
  endtask

  task automatic t_middle();
    run_scan(64'h1FF0, 1'b1);
    expect_res("R3 middle", 8, 9, 0, 8, 0, 0);
  endtask

  task automatic t_tie();
    run_scan(64'h3C3C, 1'b1);
    expect_res("R2 tie", 4, 4, 0, 4, 0, 0);
  endtask

  task automatic t_early();
    run_scan(64'h7FFF_CFFF, 1'b1); // 0..11 then 14..30
    expect_res("R5 early exit", 4, 12, 0, 4, 0, 0);
    run_scan(64'h0000_0100_7FFF_CFFF, 1'b1);
    expect_res("R5 no early upper", 22, 17, 0, 22, 0, 0);
  endtask

  task automatic t_full();
    run_scan(64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    expect_res("R1 all ones", 21, 64, 0, 21, 0, 0);
    run_scan(64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    expect_res("R6 all ones narrow", 10, 32, 0, 10, 0, 0);
  endtask

  task automatic t_wide_split();
    run_scan(64'hFFFF_FFFF_FFFC_07FF, 1'b1);
    expect_res("R7 wide window", 41, 46, 0, 31, 9, 1);
    run_scan(64'hFFFF_FFFF_FFFC_07FF, 1'b0);
    expect_res("R6 narrow window", 25, 14, 0, 25, 0, 0);
    run_scan(64'h8000_0000_0000_0000, 1'b1);
    expect_res("R7 top bit", 63, 1, 0, 31, 31, 1);
    run_scan(64'h0000_01FF_0000_0000, 1'b1);
    expect_res("R7 start32", 36, 9, 0, 31, 4, 1);
  endtask

  task automatic t_errors();
    run_scan(64'h0, 1'b1);
    expect_res("R4 zero map", 0, 0, 1, 0, 0, 0);
    run_scan(64'h0000_01FF_0000_0000, 1'b0);
    expect_res("R8 narrow upper only", 0, 0, 1, 0, 0, 0);
  endtask

  task automatic t_busy_start();
    int cyc = 0;
    @(negedge clk);
    map = 64'h1FF0; wide = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10 busy during scan", 64'(busy), 64'd1);
    repeat (4) @(negedge clk);
    map = 64'hFFFF_FFFF_FFFF_FFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 80) begin
      @(negedge clk);
      cyc++;
    end
    expect_res("R10 ignored start", 8, 9, 0, 8, 0, 0);
    repeat (10) @(negedge clk);
    check("R9 no extra done", 64'(done), 64'd0);
    check("R9 hold delay", 64'(delay), 64'd8);
    check("R10 idle after", 64'(busy), 64'd0);
  endtask

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_start_zero();
    t_middle();
    t_tie();
    t_early();
    t_full();
    t_wide_split();
    t_errors();
    t_busy_start();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule